// File: doc/BRIEF.md
# Rename Register Resource Tracker

This block sits in the dispatch stage of an out-of-order core. It keeps an in-use count of physical registers for each of several register files. Every architectural register is charged to file 0, which is always present and sees all registers. It is also charged to at most one other owning file. The charge is a per-register cost in physical registers: a wide register can cost two narrow ones.

Dispatch offers up to four destination registers on the query port. In the same cycle the block answers with a 32-bit busy mask that has one bit per register file. A clear mask means the group fits. A set bit names the file that lacks room, so stall causes can be counted per file. On the allocate port a renamed write commits its charge. On the free port a retired or removed write returns its charge. Both ports show, per file, the amount they move. A configuration port loads each file's capacity and each register's owner and cost. A capacity of zero makes a file unbounded.

Top module: `rrt_tracker`

## Requirements
- R1: A synchronous active-high reset clears every in-use count, every capacity and the error flag. Every register then maps to owner 0 with cost 1.
- R2: A file whose capacity is 0 is unbounded. Its busy bit is never set, and its count still moves with allocations and frees.
- R3: An allocation or free charges the register's cost to file 0. When the owner is not 0, it also charges the same cost to the owner. All other files get 0.
- R4: For each file, the query adds up the charges of the valid slots only. The busy bit is set when count plus that sum is strictly greater than the capacity, so an exact fit is not busy.
- R5: Bit f of `q_busy` belongs to file f. Bits at or above NUM_FILES are always 0.
- R6: When `al_en` is high, `al_amt` shows each file's charge in the same cycle, and the counts grow by it at the next rising edge. When `al_en` is low, all amounts are 0 and nothing is consumed. Counts saturate at 2^CNT_W-1.
- R7: When `fr_en` is high, `fr_amt` shows each file's charge, and the counts drop by it at the next edge. When `fr_en` is low, all amounts are 0 and nothing is released.
- R8: An allocate and a free in the same cycle are both applied to the count at the same edge.
- R9: If a count plus its allocation is below its release, the count becomes 0 and `err_underflow` is set. The flag stays set until reset.
- R10: Capacity writes (`cfg_total_we`) and map writes (`cfg_map_we`) take effect on the query from the next cycle. Map writes whose owner is at or above NUM_FILES are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_total_we | input | 1 | Load a file capacity |
| cfg_file | input | FILE_W (2) | File selected for the capacity load |
| cfg_total | input | CNT_W (8) | Capacity value, 0 = unbounded |
| cfg_map_we | input | 1 | Load a register's owner and cost |
| cfg_areg | input | AREG_W (4) | Architectural register being mapped |
| cfg_owner | input | FILE_W (2) | Owning file |
| cfg_cost | input | COST_W (2) | Cost in physical registers |
| q_valid | input | QUERY_N (4) | Valid flag per query slot |
| q_regs | input | QUERY_N*AREG_W (16) | Register ID per slot, slot i at bits [i*AREG_W +: AREG_W] |
| q_busy | output | 32 | Per-file busy mask |
| al_en | input | 1 | Allocate enable |
| al_areg | input | AREG_W (4) | Register being allocated |
| al_amt | output | NUM_FILES*CNT_W (32) | Per-file amount consumed, file f at [f*CNT_W +: CNT_W] |
| fr_en | input | 1 | Free enable |
| fr_areg | input | AREG_W (4) | Register being freed |
| fr_amt | output | NUM_FILES*CNT_W (32) | Per-file amount released |
| in_use | output | NUM_FILES*CNT_W (32) | Per-file in-use count |
| err_underflow | output | 1 | Sticky underflow flag |

## Verification
A count that has drifted shows up on `in_use` one edge after the faulty update. The busy answer of every later query in that file then goes wrong in the same cycle that query is presented. A wrong owner or cost entry shows up at once on `al_amt`/`fr_amt` and on the busy mask for any slot that names that register. An off-by-one in the comparison can only be seen at an exact fit, so that boundary is driven on purpose. A lost underflow can only be seen at a release larger than the count, so that case is driven on purpose too.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  localparam int unsigned MASK_W = 32;

  // Charge a register places on one file: file 0 sees everything, the owner sees its own.
  function automatic int unsigned file_charge(input int unsigned file_id,
                                              input int unsigned owner,
                                              input int unsigned cost);
    return (file_id == 0 || owner == file_id) ? cost : 0;
  endfunction

  // Busy when the file is bounded and the demand would not fit.
  function automatic logic over_total(input int unsigned total,
                                      input int unsigned used,
                                      input int unsigned demand);
    return (total != 0) && (used + demand > total);
  endfunction

  function automatic logic is_short(input int unsigned used,
                                    input int unsigned alloc,
                                    input int unsigned freed);
    return (used + alloc) < freed;
  endfunction

  // Next count: add, subtract, clamp to [0, cap].
  function automatic int unsigned next_count(input int unsigned used,
                                             input int unsigned alloc,
                                             input int unsigned freed,
                                             input int unsigned cap);
    int unsigned sum;
    sum = used + alloc;
    if (sum < freed) return 0;
    if (sum - freed > cap) return cap;
    return sum - freed;
  endfunction

endpackage

// File: rtl/rrt_cost_map.sv
module rrt_cost_map #(
  parameter int unsigned NUM_FILES = 4,
  parameter int unsigned NUM_AREGS = 16,
  parameter int unsigned COST_W    = 2,
  parameter int unsigned QUERY_N   = 4,
  localparam int unsigned FILE_W   = $clog2(NUM_FILES),
  localparam int unsigned AREG_W   = $clog2(NUM_AREGS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_map_we,
  input  logic [AREG_W-1:0]           cfg_areg,
  input  logic [FILE_W-1:0]           cfg_owner,
  input  logic [COST_W-1:0]           cfg_cost,
  input  logic [QUERY_N*AREG_W-1:0]   q_regs,
  input  logic [AREG_W-1:0]           al_areg,
  input  logic [AREG_W-1:0]           fr_areg,
  output logic [QUERY_N*FILE_W-1:0]   q_owner,
  output logic [QUERY_N*COST_W-1:0]   q_cost,
  output logic [FILE_W-1:0]           al_owner,
  output logic [COST_W-1:0]           al_cost,
  output logic [FILE_W-1:0]           fr_owner,
  output logic [COST_W-1:0]           fr_cost
);

  logic [FILE_W-1:0] owner_tab [NUM_AREGS];
  logic [COST_W-1:0] cost_tab  [NUM_AREGS];
  logic              map_write_ok;

  assign map_write_ok = cfg_map_we
                     && (32'(cfg_owner) < NUM_FILES)
                     && (32'(cfg_areg) < NUM_AREGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_AREGS; r++) begin
        owner_tab[r] <= '0;
        cost_tab[r]  <= COST_W'(1);
      end
    end else if (map_write_ok) begin
      owner_tab[cfg_areg] <= cfg_owner;
      cost_tab[cfg_areg]  <= cfg_cost;
    end
  end

  for (genvar s = 0; s < QUERY_N; s++) begin : g_qlook
    logic [AREG_W-1:0] slot_reg;
    assign slot_reg = q_regs[s*AREG_W +: AREG_W];
    assign q_owner[s*FILE_W +: FILE_W] = owner_tab[slot_reg];
    assign q_cost[s*COST_W +: COST_W]  = cost_tab[slot_reg];
  end

  assign al_owner = owner_tab[al_areg];
  assign al_cost  = cost_tab[al_areg];
  assign fr_owner = owner_tab[fr_areg];
  assign fr_cost  = cost_tab[fr_areg];

endmodule

// File: rtl/rrt_file_slot.sv
module rrt_file_slot #(
  parameter int unsigned FILE_ID   = 0,
  parameter int unsigned NUM_FILES = 4,
  parameter int unsigned COST_W    = 2,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned QUERY_N   = 4,
  localparam int unsigned FILE_W   = $clog2(NUM_FILES),
  localparam int unsigned CAP      = (1 << CNT_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      total_we,
  input  logic [CNT_W-1:0]          total_in,
  input  logic [QUERY_N-1:0]        q_valid,
  input  logic [QUERY_N*FILE_W-1:0] q_owner,
  input  logic [QUERY_N*COST_W-1:0] q_cost,
  input  logic                      al_en,
  input  logic [FILE_W-1:0]         al_owner,
  input  logic [COST_W-1:0]         al_cost,
  input  logic                      fr_en,
  input  logic [FILE_W-1:0]         fr_owner,
  input  logic [COST_W-1:0]         fr_cost,
  output logic                      busy,
  output logic [CNT_W-1:0]          used,
  output logic [CNT_W-1:0]          al_amt,
  output logic [CNT_W-1:0]          fr_amt,
  output logic                      underflow
);

  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] used_nxt;
  int unsigned      demand;

  always_comb begin
    demand = 0;
    for (int s = 0; s < QUERY_N; s++) begin
      if (q_valid[s]) begin
        demand += rrt_pkg::file_charge(FILE_ID,
                                       32'(q_owner[s*FILE_W +: FILE_W]),
                                       32'(q_cost[s*COST_W +: COST_W]));
      end
    end
  end

  assign busy   = rrt_pkg::over_total(32'(total_q), 32'(used_q), demand);
  assign al_amt = al_en ? CNT_W'(rrt_pkg::file_charge(FILE_ID, 32'(al_owner), 32'(al_cost)))
                        : '0;
  assign fr_amt = fr_en ? CNT_W'(rrt_pkg::file_charge(FILE_ID, 32'(fr_owner), 32'(fr_cost)))
                        : '0;
  assign underflow = rrt_pkg::is_short(32'(used_q), 32'(al_amt), 32'(fr_amt));
  assign used_nxt  = CNT_W'(rrt_pkg::next_count(32'(used_q), 32'(al_amt), 32'(fr_amt), CAP));
  assign used      = used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      used_q  <= '0;
    end else begin
      if (total_we) total_q <= total_in;
      used_q <= used_nxt;
    end
  end

endmodule

// File: rtl/rrt_tracker.sv
module rrt_tracker #(
  parameter int unsigned NUM_FILES = 4,
  parameter int unsigned NUM_AREGS = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned COST_W    = 2,
  parameter int unsigned QUERY_N   = 4,
  localparam int unsigned FILE_W   = $clog2(NUM_FILES),
  localparam int unsigned AREG_W   = $clog2(NUM_AREGS),
  localparam int unsigned MASK_W   = rrt_pkg::MASK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_total_we,
  input  logic [FILE_W-1:0]           cfg_file,
  input  logic [CNT_W-1:0]            cfg_total,
  input  logic                        cfg_map_we,
  input  logic [AREG_W-1:0]           cfg_areg,
  input  logic [FILE_W-1:0]           cfg_owner,
  input  logic [COST_W-1:0]           cfg_cost,
  input  logic [QUERY_N-1:0]          q_valid,
  input  logic [QUERY_N*AREG_W-1:0]   q_regs,
  output logic [MASK_W-1:0]           q_busy,
  input  logic                        al_en,
  input  logic [AREG_W-1:0]           al_areg,
  output logic [NUM_FILES*CNT_W-1:0]  al_amt,
  input  logic                        fr_en,
  input  logic [AREG_W-1:0]           fr_areg,
  output logic [NUM_FILES*CNT_W-1:0]  fr_amt,
  output logic [NUM_FILES*CNT_W-1:0]  in_use,
  output logic                        err_underflow
);

  // Named internal events, visible to the bound checker.
  logic [QUERY_N*FILE_W-1:0] q_owner;
  logic [QUERY_N*COST_W-1:0] q_cost;
  logic [FILE_W-1:0]         al_owner, fr_owner;
  logic [COST_W-1:0]         al_cost, fr_cost;
  logic [NUM_FILES-1:0]      file_busy;
  logic [NUM_FILES-1:0]      file_underflow;
  logic [NUM_FILES-1:0]      file_total_we;
  logic                      err_q;

  rrt_cost_map #(
    .NUM_FILES (NUM_FILES),
    .NUM_AREGS (NUM_AREGS),
    .COST_W    (COST_W),
    .QUERY_N   (QUERY_N)
  ) u_map (
    .clk        (clk),
    .rst        (rst),
    .cfg_map_we (cfg_map_we),
    .cfg_areg   (cfg_areg),
    .cfg_owner  (cfg_owner),
    .cfg_cost   (cfg_cost),
    .q_regs     (q_regs),
    .al_areg    (al_areg),
    .fr_areg    (fr_areg),
    .q_owner    (q_owner),
    .q_cost     (q_cost),
    .al_owner   (al_owner),
    .al_cost    (al_cost),
    .fr_owner   (fr_owner),
    .fr_cost    (fr_cost)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    assign file_total_we[f] = cfg_total_we && (cfg_file == FILE_W'(f));

    rrt_file_slot #(
      .FILE_ID   (f),
      .NUM_FILES (NUM_FILES),
      .COST_W    (COST_W),
      .CNT_W     (CNT_W),
      .QUERY_N   (QUERY_N)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .total_we  (file_total_we[f]),
      .total_in  (cfg_total),
      .q_valid   (q_valid),
      .q_owner   (q_owner),
      .q_cost    (q_cost),
      .al_en     (al_en),
      .al_owner  (al_owner),
      .al_cost   (al_cost),
      .fr_en     (fr_en),
      .fr_owner  (fr_owner),
      .fr_cost   (fr_cost),
      .busy      (file_busy[f]),
      .used      (in_use[f*CNT_W +: CNT_W]),
      .al_amt    (al_amt[f*CNT_W +: CNT_W]),
      .fr_amt    (fr_amt[f*CNT_W +: CNT_W]),
      .underflow (file_underflow[f])
    );
  end

  if (NUM_FILES < MASK_W) begin : g_mask_pad
    assign q_busy = {{(MASK_W-NUM_FILES){1'b0}}, file_busy};
  end else begin : g_mask_full
    assign q_busy = file_busy;
  end

  always_ff @(posedge clk) begin
    if (rst)                   err_q <= 1'b0;
    else if (|file_underflow)  err_q <= 1'b1;
  end

  assign err_underflow = err_q;

endmodule

// File: rtl/rrt_tracker_chk.sv
module rrt_tracker_chk #(
  parameter int unsigned NUM_FILES = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned FILE_W    = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_total_we,
  input logic [FILE_W-1:0]          cfg_file,
  input logic [CNT_W-1:0]           cfg_total,
  input logic [31:0]                q_busy,
  input logic                       al_en,
  input logic [NUM_FILES*CNT_W-1:0] al_amt,
  input logic                       fr_en,
  input logic [NUM_FILES*CNT_W-1:0] fr_amt,
  input logic [NUM_FILES*CNT_W-1:0] in_use,
  input logic                       err_underflow
);

  logic [CNT_W-1:0]     seen_total [NUM_FILES];
  logic [NUM_FILES-1:0] al_touch;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FILES; f++) seen_total[f] <= '0;
    end else if (cfg_total_we) begin
      seen_total[cfg_file] <= cfg_total;
    end
  end

  // R1: first cycle out of reset shows cleared counts and flag.
  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (in_use == '0 && !err_underflow));

  assert_alloc_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !al_en |-> al_amt == '0);

  assert_free_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !fr_en |-> fr_amt == '0);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!al_en && !fr_en) |=> $stable(in_use));

  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (rst)
    err_underflow |=> err_underflow);

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_pf
    logic [CNT_W-1:0] u_f, a_f, r_f;
    assign u_f = in_use[f*CNT_W +: CNT_W];
    assign a_f = al_amt[f*CNT_W +: CNT_W];
    assign r_f = fr_amt[f*CNT_W +: CNT_W];
    assign al_touch[f] = (a_f != '0);

    assert_unbounded_idle_R2: assert property (@(posedge clk) disable iff (rst)
      (seen_total[f] == '0) |-> !q_busy[f]);

    assert_same_cost_R3: assert property (@(posedge clk) disable iff (rst)
      (al_en && a_f != '0) |-> a_f == al_amt[CNT_W-1:0]);

    assert_underflow_flag_R9: assert property (@(posedge clk) disable iff (rst)
      (fr_en && (32'(u_f) + 32'(a_f) < 32'(r_f))) |=> err_underflow);
  end

  assert_single_owner_R3: assert property (@(posedge clk) disable iff (rst)
    al_en |-> $onehot0(al_touch[NUM_FILES-1:1]));

endmodule

bind rrt_tracker rrt_tracker_chk #(
  .NUM_FILES (NUM_FILES),
  .CNT_W     (CNT_W),
  .FILE_W    (FILE_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_total_we  (cfg_total_we),
  .cfg_file      (cfg_file),
  .cfg_total     (cfg_total),
  .q_busy        (q_busy),
  .al_en         (al_en),
  .al_amt        (al_amt),
  .fr_en         (fr_en),
  .fr_amt        (fr_amt),
  .in_use        (in_use),
  .err_underflow (err_underflow)
);

// File: tb/rrt_tracker_bench.sv
module rrt_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int NA = 16;
  localparam int CW = 8;
  localparam int NSTEP = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_total_we = 0;
  logic [1:0]  cfg_file = 0;
  logic [7:0]  cfg_total = 0;
  logic        cfg_map_we = 0;
  logic [3:0]  cfg_areg = 0;
  logic [1:0]  cfg_owner = 0;
  logic [1:0]  cfg_cost = 0;
  logic [3:0]  q_valid = 0;
  logic [15:0] q_regs = 0;
  logic [31:0] q_busy;
  logic        al_en = 0;
  logic [3:0]  al_areg = 0;
  logic [31:0] al_amt;
  logic        fr_en = 0;
  logic [3:0]  fr_areg = 0;
  logic [31:0] fr_amt;
  logic [31:0] in_use;
  logic        err_underflow;

  int errors = 0;
  int checks = 0;

  // Bench model.
  int m_tot [NF];
  int m_use [NF];
  int m_own [NA];
  int m_cost[NA];
  bit m_err;

  // Stimulus: [29] alloc en, [28:25] alloc reg, [24] free en, [23:20] free reg,
  // [19:16] slot valid, [15:0] four slot regs (slot0 lowest).
  localparam logic [29:0] STEPS [NSTEP] = '{
    {1'b1, 4'd0,  1'b0, 4'd0,  4'b0011, 4'd0,  4'd0,  4'd4,  4'd1 },
    {1'b1, 4'd4,  1'b0, 4'd0,  4'b0011, 4'd0,  4'd0,  4'd13, 4'd12},
    {1'b1, 4'd8,  1'b0, 4'd0,  4'b1111, 4'd3,  4'd2,  4'd1,  4'd0 },
    {1'b0, 4'd5,  1'b0, 4'd0,  4'b0001, 4'd0,  4'd0,  4'd0,  4'd9 },
    {1'b0, 4'd0,  1'b0, 4'd0,  4'b0000, 4'd0,  4'd0,  4'd0,  4'd0 },
    {1'b1, 4'd9,  1'b1, 4'd0,  4'b0001, 4'd0,  4'd0,  4'd0,  4'd6 },
    {1'b1, 4'd12, 1'b0, 4'd0,  4'b0001, 4'd0,  4'd0,  4'd0,  4'd13},
    {1'b0, 4'd0,  1'b1, 4'd4,  4'b0101, 4'd0,  4'd5,  4'd13, 4'd4 },
    {1'b1, 4'd14, 1'b0, 4'd0,  4'b0001, 4'd0,  4'd0,  4'd0,  4'd15},
    {1'b0, 4'd0,  1'b1, 4'd12, 4'b0000, 4'd0,  4'd0,  4'd0,  4'd0 },
    {1'b1, 4'd10, 1'b1, 4'd8,  4'b0011, 4'd0,  4'd0,  4'd5,  4'd7 },
    {1'b0, 4'd0,  1'b0, 4'd0,  4'b1111, 4'd11, 4'd10, 4'd9,  4'd8 }
  };

  rrt_tracker u_rrt_tracker (
    .clk(clk), .rst(rst),
    .cfg_total_we(cfg_total_we), .cfg_file(cfg_file), .cfg_total(cfg_total),
    .cfg_map_we(cfg_map_we), .cfg_areg(cfg_areg), .cfg_owner(cfg_owner), .cfg_cost(cfg_cost),
    .q_valid(q_valid), .q_regs(q_regs), .q_busy(q_busy),
    .al_en(al_en), .al_areg(al_areg), .al_amt(al_amt),
    .fr_en(fr_en), .fr_areg(fr_areg), .fr_amt(fr_amt),
    .in_use(in_use), .err_underflow(err_underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Charge of register r on file f: file 0 always, else only the owner.
  function automatic int charge(input int f, input int r);
    if (f == 0) return m_cost[r];
    return (m_own[r] == f) ? m_cost[r] : 0;
  endfunction

  task automatic model_reset();
    for (int f = 0; f < NF; f++) begin m_tot[f] = 0; m_use[f] = 0; end
    for (int r = 0; r < NA; r++) begin m_own[r] = 0; m_cost[r] = 1; end
    m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    #1;
    check("R1", "in_use after reset", in_use, 0);
    check("R1", "err after reset", err_underflow, 0);
  endtask

  task automatic set_total(input int f, input int t);
    @(negedge clk);
    cfg_total_we = 1; cfg_file = 2'(f); cfg_total = 8'(t);
    @(negedge clk);
    cfg_total_we = 0;
    m_tot[f] = t;
  endtask

  task automatic set_map(input int r, input int own, input int cost);
    @(negedge clk);
    cfg_map_we = 1; cfg_areg = 4'(r); cfg_owner = 2'(own); cfg_cost = 2'(cost);
    @(negedge clk);
    cfg_map_we = 0;
    m_own[r] = own; m_cost[r] = cost;
  endtask

  task automatic run_step(input logic [29:0] v, input string req);
    int a_amt[NF];
    int r_amt[NF];
    int dem;
    int nxt;
    logic [31:0] exp_busy;
    @(negedge clk);
    al_en = v[29]; al_areg = v[28:25]; fr_en = v[24]; fr_areg = v[23:20];
    q_valid = v[19:16]; q_regs = v[15:0];
    #1;
    exp_busy = '0;
    for (int f = 0; f < NF; f++) begin
      dem = 0;
      for (int s = 0; s < 4; s++)
        if (v[16+s]) dem += charge(f, int'(v[s*4 +: 4]));
      if (m_tot[f] != 0 && m_use[f] + dem > m_tot[f]) exp_busy[f] = 1'b1;
      a_amt[f] = v[29] ? charge(f, int'(v[28:25])) : 0;
      r_amt[f] = v[24] ? charge(f, int'(v[23:20])) : 0;
      check(req, "al_amt", al_amt[f*CW +: CW], a_amt[f]);
      check(req, "fr_amt", fr_amt[f*CW +: CW], r_amt[f]);
    end
    check(req, "busy mask", q_busy, exp_busy);
    @(posedge clk);
    #1;
    for (int f = 0; f < NF; f++) begin
      nxt = m_use[f] + a_amt[f] - r_amt[f];
      if (nxt < 0) begin nxt = 0; m_err = 1; end
      if (nxt > 255) nxt = 255;
      m_use[f] = nxt;
      check(req, "in_use", in_use[f*CW +: CW], m_use[f]);
    end
    check(req, "err_underflow", err_underflow, m_err);
    al_en = 0; fr_en = 0; q_valid = 0;
  endtask

  function automatic string step_req(input int i);
    case (i)
      0: return "R6";  1: return "R4";  2: return "R3";  3: return "R6";
      4: return "R7";  5: return "R8";  6: return "R4";  7: return "R7";
      8: return "R3";  9: return "R7";  10: return "R8"; default: return "R2";
    endcase
  endfunction

  initial begin
    model_reset();
    do_reset();

    // R1: defaults are unbounded files, every register owner 0 cost 1.
    run_step({1'b1, 4'd3, 1'b0, 4'd0, 4'b1111, 4'd15, 4'd7, 4'd3, 4'd1}, "R1");

    do_reset();
    // Capacities: f0=10, f1=4, f2=unbounded, f3=3.
    set_total(0, 10); set_total(1, 4); set_total(2, 0); set_total(3, 3);
    for (int r = 0; r < 4; r++)  set_map(r, 1, 1);
    for (int r = 4; r < 8; r++)  set_map(r, 1, 2);
    for (int r = 8; r < 12; r++) set_map(r, 2, 1);
    set_map(12, 3, 3); set_map(13, 3, 3);

    for (int i = 0; i < NSTEP; i++) run_step(STEPS[i], step_req(i));

    // R5 and R10: file 3 bounded at 3, demand 6 -> busy, upper bits clear.
    @(negedge clk);
    q_valid = 4'b0011; q_regs = {8'd0, 4'd13, 4'd12};
    #1;
    check("R5", "busy bit 3", q_busy[3], 1);
    check("R5", "upper mask bits", q_busy[31:NF], 0);
    q_valid = 0;
    set_total(3, 0);
    @(negedge clk);
    q_valid = 4'b0011; q_regs = {8'd0, 4'd13, 4'd12};
    #1;
    check("R10", "bit 3 after capacity 0", q_busy[3], 0);
    q_valid = 0;
    set_total(3, 6);
    @(negedge clk);
    q_valid = 4'b0011; q_regs = {8'd0, 4'd13, 4'd12};
    #1;
    check("R4", "exact fit not busy", q_busy[3], 0);
    q_valid = 0;
    set_total(3, 5);
    @(negedge clk);
    q_valid = 4'b0011; q_regs = {8'd0, 4'd13, 4'd12};
    #1;
    check("R10", "bit 3 after capacity 5", q_busy[3], 1);
    q_valid = 0;

    // R10: out-of-range owner write would be ignored (owner field fits all 4 files here),
    // so a remap of register 12 to owner 2 must move its charge.
    set_map(12, 2, 1);
    run_step({1'b1, 4'd12, 1'b0, 4'd0, 4'b0001, 4'd0, 4'd0, 4'd0, 4'd12}, "R10");

    // R9: underflow from a clean reset, then stickiness, then reset clears.
    do_reset();
    run_step({1'b0, 4'd0, 1'b1, 4'd0, 4'b0000, 16'd0}, "R9");
    check("R9", "flag set", err_underflow, 1);
    run_step({1'b0, 4'd0, 1'b0, 4'd0, 4'b0000, 16'd0}, "R9");
    check("R9", "flag sticky", err_underflow, 1);
    do_reset();
    check("R1", "flag cleared by reset", err_underflow, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule